// File: doc/BRIEF.md
# Exception Control Register Unit

This block keeps the three exception-control registers of a 32-bit load/store core: a status word, a cause word and a saved return address. These are selected by register numbers 12, 13 and 14. Six hardware interrupt lines and two software-settable levels feed an eight-bit pending field. The pending field is combined with an eight-bit enable mask, a global enable bit and an exception-level bit to decide whether an interrupt is due. The core's control unit also reports synchronous traps together with a five-bit reason code.

When an exception is taken, the unit raises `exc_take` in the same cycle. The core then jumps to the constant handler address. On the next clock edge the unit sets the exception level, records the reason code and the branch-delay flag, and saves a return address. For interrupts the saved address is the next instruction. For traps it is the faulting instruction. Register move operations read and write the three registers by number. An exception-return strobe clears the exception level, and the core takes `ret_pc` as its new PC.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After reset, register 12 reads 0x00000010 (only the user-mode bit, bit 4, is set), register 13 reads 0, register 14 reads 0, and `exc_take` and `irq_pending` are low.
- R2: A high level on `irq_lines[i]` sets cause pending bit 10+i at the next clock edge. This happens whatever the mask, global enable or exception level. The receiver interrupt is `irq_lines[1]` (bit 11) and the transmitter interrupt is `irq_lines[0]` (bit 10).
- R3: A pending bit stays set after its line falls, until a move to register 13 writes it to 0 (cause bits 15:8 take write data bits 15:8).
- R4: `irq_pending` is high exactly when status bit 0 (global enable) is 1, status bit 1 (exception level) is 0, and pending bits 15:8 AND mask bits 15:8 of status is nonzero. An interrupt is taken (`exc_take`) only when `at_boundary` is also high.
- R5: Taking an interrupt sets the exception level, writes exception code 0 into cause bits 6:2, and saves `pc_next` in register 14, all at the next clock edge.
- R6: A trap (`trap_req`) raises `exc_take` in the same cycle and takes priority over an interrupt. At the next edge it saves `pc_next - 4` in register 14 and writes `trap_code` into cause bits 6:2. The codes are 4 load/fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction and 12 overflow.
- R7: `handler_pc` is always 0x80000180.
- R8: `eret` clears the exception level at the next edge, and `ret_pc` always shows register 14.
- R9: Moves write status bits 15:8, 1 and 0, cause bits 15:8 and all of register 14. Status bit 4 always reads 1. Cause bit 31 and the code field are not changed by moves. Any other register number reads 0.
- R10: Cause bit 31 records `branch_delay` when an exception is taken.
- R11: Software pending bits 9:8, once set by a move, raise `irq_pending` when they are enabled by the mask and the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 6 | Hardware interrupt request levels |
| at_boundary | input | 1 | Core is between instructions and may accept an interrupt |
| trap_req | input | 1 | Synchronous trap reported by control |
| trap_code | input | 5 | Reason code of the trap |
| branch_delay | input | 1 | Faulting instruction sits in a delay slot |
| pc_next | input | 32 | Incremented PC of the current instruction |
| eret | input | 1 | Exception-return strobe |
| reg_num | input | 5 | Register number for moves |
| reg_wr | input | 1 | Move-to write strobe |
| reg_wdata | input | 32 | Move-to data |
| reg_rdata | output | 32 | Move-from data |
| exc_take | output | 1 | Exception taken this cycle |
| irq_pending | output | 1 | Enabled interrupt is waiting |
| handler_pc | output | 32 | Handler entry address |
| ret_pc | output | 32 | Saved return address |

## Verification
The bench pulses interrupt lines while they are masked and globally disabled. A design that gates capture with the mask would lose these requests, and one that forgets them once the line falls would fail the later read of register 13. It checks the saved address for both kinds of exception: an off-by-four in either path shows up in register 14. It sends a trap while an enabled software interrupt is waiting, which catches a reversed priority through a code of 0 or an EPC that is not reduced by four. It also writes all ones to the status and cause registers, which exposes a writable user-mode bit, a writable code field or a writable branch-delay bit.

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs #(
  parameter logic [31:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  irq_lines,
  input  logic        at_boundary,
  input  logic        trap_req,
  input  logic [4:0]  trap_code,
  input  logic        branch_delay,
  input  logic [31:0] pc_next,
  input  logic        eret,
  input  logic [4:0]  reg_num,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        exc_take,
  output logic        irq_pending,
  output logic [31:0] handler_pc,
  output logic [31:0] ret_pc
);
  localparam logic [4:0] NUM_STATUS = 5'd12;
  localparam logic [4:0] NUM_CAUSE  = 5'd13;
  localparam logic [4:0] NUM_EPC    = 5'd14;

  logic [7:0]  mask_q, pend_q;
  logic        ie_q, exl_q, bd_q;
  logic [4:0]  code_q;
  logic [31:0] epc_q;

  wire wr_status = reg_wr && (reg_num == NUM_STATUS);
  wire wr_cause  = reg_wr && (reg_num == NUM_CAUSE);
  wire wr_epc    = reg_wr && (reg_num == NUM_EPC);

  assign irq_pending = ie_q & ~exl_q & (|(pend_q & mask_q));
  assign exc_take    = trap_req | (at_boundary & irq_pending);
  assign handler_pc  = HANDLER_ADDR;
  assign ret_pc      = epc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      ie_q   <= 1'b0;
      exl_q  <= 1'b0;
      bd_q   <= 1'b0;
      code_q <= '0;
      epc_q  <= '0;
    end else begin
      pend_q <= (wr_cause ? reg_wdata[15:8] : pend_q) | {irq_lines, 2'b00};
      if (wr_status) begin
        mask_q <= reg_wdata[15:8];
        ie_q   <= reg_wdata[0];
      end
      if (exc_take) begin
        exl_q  <= 1'b1;
        bd_q   <= branch_delay;
        code_q <= trap_req ? trap_code : 5'd0;
        epc_q  <= trap_req ? (pc_next - 32'd4) : pc_next;
      end else begin
        if (wr_status)  exl_q <= reg_wdata[1];
        else if (eret)  exl_q <= 1'b0;
        if (wr_epc)     epc_q <= reg_wdata;
      end
    end
  end

  always_comb begin
    case (reg_num)
      NUM_STATUS: reg_rdata = {16'd0, mask_q, 3'd0, 1'b1, 2'd0, exl_q, ie_q};
      NUM_CAUSE:  reg_rdata = {bd_q, 15'd0, pend_q, 1'b0, code_q, 2'd0};
      NUM_EPC:    reg_rdata = epc_q;
      default:    reg_rdata = 32'd0;
    endcase
  end

  AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines != 6'd0) |=> ((pend_q[7:2] & $past(irq_lines)) == $past(irq_lines))); // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (ie_q && !exl_q)); // R4
  AST_IRQ_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !trap_req) |=> (epc_q == $past(pc_next) && code_q == 5'd0 && exl_q)); // R5
  AST_TRAP_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (epc_q == $past(pc_next) - 32'd4 && code_q == $past(trap_code))); // R6
  AST_ERET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !exc_take && !wr_status) |=> !exl_q); // R8
  AST_USER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_num == NUM_STATUS) |-> reg_rdata[4]); // R9
  AST_BD_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (bd_q == $past(branch_delay))); // R10
endmodule

// File: tb/exc_ctrl_regs_tb.sv
module exc_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  irq_lines = '0;
  logic        at_boundary = 1'b0;
  logic        trap_req = 1'b0;
  logic [4:0]  trap_code = '0;
  logic        branch_delay = 1'b0;
  logic [31:0] pc_next = '0;
  logic        eret = 1'b0;
  logic [4:0]  reg_num = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, handler_pc, ret_pc;
  logic        exc_take, irq_pending;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  exc_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .at_boundary(at_boundary),
    .trap_req(trap_req), .trap_code(trap_code), .branch_delay(branch_delay),
    .pc_next(pc_next), .eret(eret), .reg_num(reg_num), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_take(exc_take),
    .irq_pending(irq_pending), .handler_pc(handler_pc), .ret_pc(ret_pc)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [4:0] num, output logic [31:0] val);
    reg_num = num;
    #1;
    val = reg_rdata;
  endtask

  task automatic wr(input logic [4:0] num, input logic [31:0] val);
    reg_num = num; reg_wdata = val; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic do_eret();
    eret = 1'b1;
    tick();
    eret = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'd12, v); check("R1 status", v, 32'h10);
    rd(5'd13, v); check("R1 cause", v, 32'h0);
    rd(5'd14, v); check("R1 epc", v, 32'h0);
    check("R1 take", {31'd0, exc_take}, 32'd0);
    check("R1 pending", {31'd0, irq_pending}, 32'd0);
    check("R7 handler", handler_pc, 32'h8000_0180);
  endtask

  task automatic t_masked_capture();
    logic [31:0] v;
    irq_lines = 6'b000010; tick(); irq_lines = '0;
    rd(5'd13, v); check("R2 receiver bit 11", v, 32'h0800);
    check("R4 masked no irq", {31'd0, irq_pending}, 32'd0);
    irq_lines = 6'b000001; tick(); irq_lines = '0;
    tick(); tick(); tick();
    rd(5'd13, v); check("R3 held after line falls", v, 32'h0C00);
    wr(5'd13, 32'h0);
    rd(5'd13, v); check("R3 cleared by write", v, 32'h0);
  endtask

  task automatic t_irq_take();
    logic [31:0] v;
    wr(5'd12, 32'h0801);
    irq_lines = 6'b000010; tick(); irq_lines = '0;
    check("R4 irq_pending", {31'd0, irq_pending}, 32'd1);
    check("R4 no take off boundary", {31'd0, exc_take}, 32'd0);
    pc_next = 32'h0040_0010; at_boundary = 1'b1;
    #1 check("R4 take at boundary", {31'd0, exc_take}, 32'd1);
    tick(); at_boundary = 1'b0;
    rd(5'd12, v); check("R5 status exl", v, 32'h0813);
    rd(5'd13, v); check("R5 cause code 0", v, 32'h0800);
    rd(5'd14, v); check("R5 epc next", v, 32'h0040_0010);
    check("R4 blocked by exl", {31'd0, irq_pending}, 32'd0);
    check("R8 ret_pc", ret_pc, 32'h0040_0010);
  endtask

  task automatic t_eret();
    logic [31:0] v;
    do_eret();
    rd(5'd12, v); check("R8 exl cleared", v, 32'h0811);
    check("R4 pending returns", {31'd0, irq_pending}, 32'd1);
    wr(5'd13, 32'h0);
    check("R3 cleared no irq", {31'd0, irq_pending}, 32'd0);
  endtask

  task automatic t_trap_priority();
    logic [31:0] v;
    wr(5'd12, 32'h0101);
    wr(5'd13, 32'h0100);
    check("R11 software irq", {31'd0, irq_pending}, 32'd1);
    pc_next = 32'h0040_0024; trap_req = 1'b1; trap_code = 5'd12;
    branch_delay = 1'b1; at_boundary = 1'b1;
    #1 check("R6 take same cycle", {31'd0, exc_take}, 32'd1);
    tick();
    trap_req = 1'b0; branch_delay = 1'b0; at_boundary = 1'b0;
    rd(5'd13, v); check("R6 R10 cause", v, 32'h8000_0130);
    rd(5'd14, v); check("R6 epc minus 4", v, 32'h0040_0020);
    rd(5'd12, v); check("R6 status", v, 32'h0113);
    do_eret();
    wr(5'd13, 32'h0);
    wr(5'd12, 32'h0);
  endtask

  task automatic t_trap_codes();
    logic [31:0] v;
    for (int k = 4; k <= 10; k++) begin
      pc_next = 32'h0040_1000 + 32'(k * 16);
      trap_req = 1'b1; trap_code = 5'(k);
      tick();
      trap_req = 1'b0;
      rd(5'd13, v); check("R6 code", v, 32'(k) << 2);
      rd(5'd14, v); check("R6 epc", v, 32'h0040_1000 + 32'(k * 16) - 32'd4);
      do_eret();
    end
  endtask

  task automatic t_reg_access();
    logic [31:0] v;
    wr(5'd12, 32'hFFFF_FFFF);
    rd(5'd12, v); check("R9 status writable", v, 32'hFF13);
    wr(5'd12, 32'h0);
    rd(5'd12, v); check("R9 user bit fixed", v, 32'h10);
    wr(5'd14, 32'h1234_5678);
    rd(5'd14, v); check("R9 epc write", v, 32'h1234_5678);
    check("R8 ret_pc follows", ret_pc, 32'h1234_5678);
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, v); check("R9 cause code bd locked", v, 32'hFF28);
    check("R4 disabled no irq", {31'd0, irq_pending}, 32'd0);
    wr(5'd13, 32'h0);
    rd(5'd13, v); check("R9 cause cleared", v, 32'h28);
    rd(5'd5, v);  check("R9 unimpl 5", v, 32'h0);
    rd(5'd15, v); check("R9 unimpl 15", v, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_masked_capture();
    t_irq_take();
    t_eret();
    t_trap_priority();
    t_trap_codes();
    t_reg_access();
    finish_run();
  end
endmodule